// File: doc/BRIEF.md
# Signal Notification Register with Merge Mode

This block holds one 32-bit notification word that remote senders deposit and a single local consumer collects. Senders present a word on a write strobe. The consumer raises a read request. If no word is held, the request stalls until one arrives. A non-stalling occupancy query reports whether a word is waiting. A pending flag follows the occupancy and can drive an event or interrupt unit.

A static mode input picks one of two policies. In keep-first mode, the first word written is kept and later words are discarded until the consumer collects it. In merge mode, every word is combined into the held value with a bitwise OR. This lets many senders each set their own bits in one shared word. The mode is sampled only while nothing is held. Collecting the word clears the register to zero; it is not a queue pop.

Top module: `sig_notify_reg`

## Requirements
- R1: The held word is 32 bits wide and the capacity is one entry. `occ_o` is 1 while a word is held and 0 otherwise, in the same cycle, and a query never stalls.
- R2: While `rd_req_i` is high and no word is held, `rd_ack_o` stays 0. The reader is stalled until a word is held, and `rd_ack_o` rises in the first cycle the word is held.
- R3: A read completes in a cycle where `rd_req_i` and `rd_ack_o` are both 1. In that cycle `rd_data_o` carries the held word. After the clock edge the register is zero and nothing is pending, unless R7 applies.
- R4: In keep-first mode (`merge_mode_i` = 0), a write while nothing is held is stored. Writes while a word is held are discarded until that word is read.
- R5: In merge mode (`merge_mode_i` = 1), each write is ORed into the held word. Writes of 0x1, 0x2 and 0x4 read back as 0x7.
- R6: Every accepted write makes `pend_o` 1 from the next cycle, even when the written word is zero. `pend_o` stays 1 until a read completes.
- R7: A write in the same cycle as a completing read is not lost. The read returns the old word, and the written word becomes the new held word, still pending.
- R8: Reset clears the word, `pend_o` and the mode. `merge_mode_i` is sampled only at clock edges where nothing is held; changes while a word is held take effect once it is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| merge_mode_i | input | 1 | 0 keep-first, 1 bitwise-OR merge; sampled while idle |
| wr_i | input | 1 | Write strobe from a sender |
| wr_data_i | input | DATA_W | Word written by the sender |
| rd_req_i | input | 1 | Consumer read request, held until acknowledged |
| rd_ack_o | output | 1 | Read completes this cycle |
| rd_data_o | output | DATA_W | Held word, valid with `rd_ack_o` |
| occ_o | output | 1 | Occupancy query: 1 when a word is held |
| pend_o | output | 1 | Pending indication for an event unit |

## Verification
Five properties are checked on every cycle:
- an acknowledge is never given without a held word;
- a read without a colliding write leaves the register empty and zero;
- a write always leaves a word pending;
- a discarded write leaves the held word unchanged, and a merged write yields exactly the OR;
- a write that collides with a read becomes the new held word.

Some behaviour appears only over a whole scenario, so only the bench's scenarios show it:
- the long stall and its release by a late sender;
- a zero word counting as a signal;
- the mode change that is ignored until the register drains;
- the clearing effect of a reset taken while a word is held.

// File: rtl/sig_notify_pkg.sv
package sig_notify_pkg;
   typedef enum logic {
      MODE_KEEP  = 1'b0,
      MODE_MERGE = 1'b1
   } sig_mode_e;
endpackage

// File: rtl/sig_notify_update.sv
module sig_notify_update #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] held_i,
   input  logic              pend_i,
   input  logic              merge_i,
   input  logic              rd_fire_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] nxt_val_o,
   output logic              nxt_pend_o
);
   logic [DATA_W-1:0] base_val;
   logic              base_pend;

   always_comb begin
      base_val  = rd_fire_i ? '0 : held_i;
      base_pend = pend_i & ~rd_fire_i;
      nxt_val_o  = base_val;
      nxt_pend_o = base_pend;
      if (wr_i) begin
         nxt_pend_o = 1'b1;
         if (!base_pend)   nxt_val_o = wdata_i;
         else if (merge_i) nxt_val_o = base_val | wdata_i;
      end
   end
endmodule

// File: rtl/sig_notify_rdport.sv
module sig_notify_rdport (
   input  logic rd_req_i,
   input  logic pend_i,
   output logic rd_fire_o,
   output logic occ_o
);
   assign rd_fire_o = rd_req_i & pend_i;
   assign occ_o     = pend_i;
endmodule

// File: rtl/sig_notify_reg.sv
module sig_notify_reg
   import sig_notify_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter bit MERGE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              merge_mode_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              rd_req_i,
   output logic              rd_ack_o,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              occ_o,
   output logic              pend_o
);
   localparam logic [DATA_W-1:0] ZERO_W = '0;

   if (DATA_W < 1) begin : g_bad_width
      $error("sig_notify_reg: DATA_W must be at least 1");
   end

   logic [DATA_W-1:0] val_q, nxt_val;
   logic              pend_q, nxt_pend;
   logic              rd_fire;
   logic              merge_en;

   if (MERGE_EN) begin : g_merge
      sig_mode_e mode_q;
      always_ff @(posedge clk) begin
         if (!rst_n)       mode_q <= MODE_KEEP;
         else if (!pend_q) mode_q <= sig_mode_e'(merge_mode_i);
      end
      assign merge_en = (mode_q == MODE_MERGE);
   end else begin : g_keep_only
      assign merge_en = 1'b0;
   end

   sig_notify_rdport u_rdport (
      .rd_req_i (rd_req_i),
      .pend_i   (pend_q),
      .rd_fire_o(rd_fire),
      .occ_o    (occ_o)
   );

   sig_notify_update #(.DATA_W(DATA_W)) u_update (
      .held_i    (val_q),
      .pend_i    (pend_q),
      .merge_i   (merge_en),
      .rd_fire_i (rd_fire),
      .wr_i      (wr_i),
      .wdata_i   (wr_data_i),
      .nxt_val_o (nxt_val),
      .nxt_pend_o(nxt_pend)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         val_q  <= ZERO_W;
         pend_q <= 1'b0;
      end else begin
         val_q  <= nxt_val;
         pend_q <= nxt_pend;
      end
   end

   assign rd_ack_o  = rd_fire;
   assign rd_data_o = val_q;
   assign pend_o    = pend_q;
endmodule

// File: rtl/sig_notify_chk.sv
module sig_notify_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_i,
   input logic [DATA_W-1:0] wr_data_i,
   input logic              rd_req_i,
   input logic              rd_ack_o,
   input logic [DATA_W-1:0] rd_data_o,
   input logic              pend_o,
   input logic              merge_en
);
   AST_ACK_NEEDS_SIGNAL: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ack_o |-> (pend_o && rd_req_i)); // R2
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ack_o && !wr_i) |=> (!pend_o && rd_data_o == '0)); // R3
   AST_WRITE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> pend_o); // R6
   AST_KEEP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o && !rd_ack_o && wr_i && !merge_en) |=> $stable(rd_data_o)); // R4
   AST_MERGE_OR: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o && !rd_ack_o && wr_i && merge_en)
      |=> (rd_data_o == ($past(rd_data_o) | $past(wr_data_i)))); // R5
   AST_COLLIDE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ack_o && wr_i) |=> (pend_o && rd_data_o == $past(wr_data_i))); // R7
endmodule

bind sig_notify_reg sig_notify_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_i     (wr_i),
   .wr_data_i(wr_data_i),
   .rd_req_i (rd_req_i),
   .rd_ack_o (rd_ack_o),
   .rd_data_o(rd_data_o),
   .pend_o   (pend_o),
   .merge_en (merge_en)
);

// File: tb/tb_sig_notify_reg.sv
module tb_sig_notify_reg;
   localparam int DW = 32;
   localparam int NV = 23;

   typedef struct packed {
      logic          mode;
      logic          wr;
      logic [DW-1:0] wdata;
      logic          rd;
      logic          ack;
      logic [DW-1:0] data;
      logic          occ;
   } vec_t;

   // Each row is one cycle: inputs, then the ack/data/occupancy seen before its edge.
   localparam vec_t TBL [NV] = '{
      '{1'b0, 1'b0, 32'h0,   1'b0, 1'b0, 32'h0,   1'b0}, // R1 idle
      '{1'b0, 1'b1, 32'hA5,  1'b0, 1'b0, 32'h0,   1'b0}, // R4 first write
      '{1'b0, 1'b1, 32'h11,  1'b0, 1'b0, 32'h0,   1'b1}, // R4 dropped
      '{1'b0, 1'b0, 32'h0,   1'b1, 1'b1, 32'hA5,  1'b1}, // R3 read
      '{1'b0, 1'b0, 32'h0,   1'b1, 1'b0, 32'h0,   1'b0}, // R2 stall
      '{1'b0, 1'b1, 32'h33,  1'b1, 1'b0, 32'h0,   1'b0}, // R2 still stalled
      '{1'b0, 1'b0, 32'h0,   1'b1, 1'b1, 32'h33,  1'b1}, // R2 released
      '{1'b0, 1'b1, 32'h0,   1'b0, 1'b0, 32'h0,   1'b0}, // R6 zero write
      '{1'b0, 1'b0, 32'h0,   1'b0, 1'b0, 32'h0,   1'b1}, // R6 zero pending
      '{1'b0, 1'b0, 32'h0,   1'b1, 1'b1, 32'h0,   1'b1}, // R3 read zero
      '{1'b1, 1'b1, 32'h1,   1'b0, 1'b0, 32'h0,   1'b0}, // R5
      '{1'b1, 1'b1, 32'h2,   1'b0, 1'b0, 32'h0,   1'b1}, // R5
      '{1'b1, 1'b1, 32'h4,   1'b0, 1'b0, 32'h0,   1'b1}, // R5
      '{1'b0, 1'b1, 32'h8,   1'b0, 1'b0, 32'h0,   1'b1}, // R8 mode change ignored
      '{1'b0, 1'b1, 32'h100, 1'b1, 1'b1, 32'hF,   1'b1}, // R7 collide
      '{1'b0, 1'b0, 32'h0,   1'b0, 1'b0, 32'h0,   1'b1}, // R7 still pending
      '{1'b0, 1'b1, 32'h200, 1'b0, 1'b0, 32'h0,   1'b1}, // R8 still merging
      '{1'b0, 1'b0, 32'h0,   1'b1, 1'b1, 32'h300, 1'b1}, // R8
      '{1'b0, 1'b0, 32'h0,   1'b0, 1'b0, 32'h0,   1'b0}, // R8 mode taken idle
      '{1'b0, 1'b1, 32'h5,   1'b0, 1'b0, 32'h0,   1'b0}, // R4
      '{1'b0, 1'b1, 32'h6,   1'b0, 1'b0, 32'h0,   1'b1}, // R4 dropped
      '{1'b0, 1'b0, 32'h0,   1'b1, 1'b1, 32'h5,   1'b1}, // R4 read
      '{1'b0, 1'b0, 32'h0,   1'b0, 1'b0, 32'h0,   1'b0}  // R3 empty
   };

   logic          clk = 1'b0;
   logic          rst_n;
   logic          merge_mode_i, wr_i, rd_req_i;
   logic [DW-1:0] wr_data_i;
   logic          rd_ack_o, occ_o, pend_o;
   logic [DW-1:0] rd_data_o;
   int            checks = 0;
   int            errors = 0;
   int            cycles = 0;

   always #2 clk = ~clk;

   sig_notify_reg #(.DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .merge_mode_i(merge_mode_i),
      .wr_i(wr_i), .wr_data_i(wr_data_i), .rd_req_i(rd_req_i),
      .rd_ack_o(rd_ack_o), .rd_data_o(rd_data_o), .occ_o(occ_o), .pend_o(pend_o)
   );

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input logic m, input logic w, input logic [DW-1:0] d, input logic r);
      @(negedge clk);
      merge_mode_i = m; wr_i = w; wr_data_i = d; rd_req_i = r;
      #1;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; merge_mode_i = 1'b0; wr_i = 1'b0; wr_data_i = '0; rd_req_i = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk("R8 reset pend", {31'b0, pend_o}, 32'h0);
      chk("R8 reset data", rd_data_o, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         drive(TBL[i].mode, TBL[i].wr, TBL[i].wdata, TBL[i].rd);
         chk($sformatf("R2 ack row %0d", i), {31'b0, rd_ack_o}, {31'b0, TBL[i].ack});
         chk($sformatf("R1 occ row %0d", i), {31'b0, occ_o}, {31'b0, TBL[i].occ});
         chk($sformatf("R6 pend row %0d", i), {31'b0, pend_o}, {31'b0, TBL[i].occ});
         if (TBL[i].ack)
            chk($sformatf("R3 data row %0d", i), rd_data_o, TBL[i].data);
      end

      // R3: data is zero after the final read
      chk("R3 cleared data", rd_data_o, 32'h0);

      // R2: long stall, then a late write releases the reader
      for (int k = 0; k < 6; k++) begin
         drive(1'b0, 1'b0, '0, 1'b1);
         chk("R2 long stall", {31'b0, rd_ack_o}, 32'h0);
      end
      drive(1'b0, 1'b1, 32'hDEADBEEF, 1'b1);
      drive(1'b0, 1'b0, '0, 1'b1);
      chk("R2 release ack", {31'b0, rd_ack_o}, 32'h1);
      chk("R2 release data", rd_data_o, 32'hDEADBEEF);

      // R8: reset while a word is held clears it and the mode
      drive(1'b1, 1'b1, 32'h0F0F, 1'b0);
      drive(1'b0, 1'b0, '0, 1'b0);
      chk("R8 held before reset", {31'b0, pend_o}, 32'h1);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      #1;
      chk("R8 reset clears pend", {31'b0, pend_o}, 32'h0);
      chk("R8 reset clears occ", {31'b0, occ_o}, 32'h0);
      chk("R8 reset clears data", rd_data_o, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // R4: keep-first after reset with all-ones then another word
      drive(1'b0, 1'b1, 32'hFFFF_FFFF, 1'b0);
      drive(1'b0, 1'b1, 32'h1234, 1'b0);
      drive(1'b0, 1'b0, '0, 1'b1);
      chk("R4 keep first full width", rd_data_o, 32'hFFFF_FFFF);
      drive(1'b0, 1'b0, '0, 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule